// File: doc/BRIEF.md
# Converter Calibration Sequencer

This block decides when the converter's self-calibration runs. After the power-on reset it waits a power-up delay, with one of two lengths picked by a delay-select input, and then starts one calibration. Later calibrations start only on a valid command. In normal mode the command is a pulse pattern on the calibration pin. In extended mode it is a zero-to-one transition of a software-owned calibration bit.

Power-down freezes the power-up delay counter and blocks any calibration start. It also aborts a calibration that is running. When clock phase adjustment is enabled, a command counts only if the RTD input is high. The analog trimming is modelled as a busy window of fixed length, and each window that finishes is marked by a one-cycle done pulse.

Top module: `cal_sequencer`

## Requirements
- R1: While reset is asserted, and until the first calibration starts, `cal_busy` and `cal_done` are both 0.
- R2: With `pd` low throughout, `cal_busy` first rises exactly DLY+3 clock edges after `rst_n` is released. DLY is DLY_SHORT when `dly_sel`=0 and DLY_LONG when `dly_sel`=1. The 3 extra edges are the two-stage reset synchronizer plus one initial state.
- R3: Each clock edge that samples `pd`=1 during the power-up delay extends the delay by exactly one clock.
- R4: A calibration holds `cal_busy` high for exactly BUSY_LEN cycles. `cal_done` is then high for exactly one cycle, the first cycle after `cal_busy` falls.
- R5: In normal mode (`ext_mode`=0), if `cal_pin` is 1 in the first active cycle after reset, the power-up calibration does not run. The next calibration comes only from a valid pin command.
- R6: In normal mode, a pin command is valid when `cal_pin` is 0 for at least LOW_MIN consecutive clock samples and then 1 for at least HIGH_MIN consecutive samples. Shorter low or high runs start nothing. One valid pattern starts one calibration.
- R7: In extended mode (`ext_mode`=1), a 0-to-1 change of `cal_reg_bit` requests one calibration. A bit that stays high requests nothing more. A bit already high at reset release counts as no change.
- R8: In extended mode the pin patterns are ignored. In normal mode changes of `cal_reg_bit` are ignored.
- R9: With `phase_adj_en`=1, a request starts a calibration only if `rtd`=1. With `phase_adj_en`=0, the value of `rtd` has no effect.
- R10: No calibration starts while `pd`=1. A request seen while `pd` is high is discarded, not held until `pd` falls.
- R11: If `pd` rises during a calibration, `cal_busy` falls on the next cycle and no `cal_done` follows. The calibration does not restart by itself.
- R12: Requests that arrive during the power-up delay or during a running calibration are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Power-on reset, asynchronous active-low, released synchronously inside |
| cal_pin | input | 1 | Calibration command pin (normal mode) |
| cal_reg_bit | input | 1 | Software calibration bit (extended mode) |
| ext_mode | input | 1 | 1 selects extended (register) control, 0 selects pin control |
| pd | input | 1 | Power-down |
| dly_sel | input | 1 | Power-up delay select: 0 short, 1 long |
| phase_adj_en | input | 1 | Clock phase adjustment enabled |
| rtd | input | 1 | Permits calibration while phase adjustment is enabled |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | One-cycle pulse when a calibration completes |

## Verification
Most internal faults show up at the ports within a handful of clocks.

- A wrong state or counter value moves the first rise of `cal_busy` away from its exact cycle after reset. It can also change the width of the busy window, or produce or drop a done pulse. These effects appear within one delay or one busy length.
- A fault in the pin qualifier shows as a calibration that starts, or fails to start, one to two cycles after the HIGH_MIN-th high sample. The bench sweeps every low and high run length around both limits.
- Gating faults (mode, RTD, power-down, the busy or delay window) show as an extra or missing `cal_busy` window within two cycles of the request.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_WAIT = 2'd1,
    ST_IDLE = 2'd2,
    ST_BUSY = 2'd3
  } cal_state_e;

endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/cal_pin_qualifier.sv
module cal_pin_qualifier #(
  parameter int unsigned LOW_MIN  = 80,
  parameter int unsigned HIGH_MIN = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_pin,
  output logic cmd_pulse
);

  localparam int LW = $clog2(LOW_MIN + 1);
  localparam int HW = $clog2(HIGH_MIN + 1);
  localparam logic [LW-1:0] LOW_LIM  = LW'(LOW_MIN);
  localparam logic [HW-1:0] HIGH_LIM = HW'(HIGH_MIN);

  logic          pin_q;
  logic [LW-1:0] low_q, low_d;
  logic [HW-1:0] high_q, high_d;
  logic          fire;
  logic          cmd_q;

  // Low run: saturating count of consecutive low samples, held while high.
  // High run: saturating count of consecutive high samples.
  always_comb begin
    low_d  = low_q;
    high_d = high_q;
    if (!cal_pin) begin
      high_d = '0;
      if (pin_q) begin
        low_d = LW'(1);
      end else if (low_q != LOW_LIM) begin
        low_d = low_q + 1'b1;
      end
    end else begin
      if (!pin_q) begin
        high_d = HW'(1);
      end else if (high_q != HIGH_LIM) begin
        high_d = high_q + 1'b1;
      end
    end
    fire = cal_pin && (low_q == LOW_LIM) && (high_d == HIGH_LIM) && (high_q != HIGH_LIM);
    if (fire) begin
      low_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b1;
      low_q  <= '0;
      high_q <= '0;
      cmd_q  <= 1'b0;
    end else begin
      pin_q  <= cal_pin;
      low_q  <= low_d;
      high_q <= high_d;
      cmd_q  <= fire;
    end
  end

  assign cmd_pulse = cmd_q;

endmodule

// File: rtl/cal_reg_edge.sv
module cal_reg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_reg_bit,
  output logic cmd_pulse
);

  logic prev_q;
  logic edge_q;

  // prev resets to 1 so a bit already set at reset release is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      edge_q <= 1'b0;
    end else begin
      prev_q <= cal_reg_bit;
      edge_q <= cal_reg_bit & ~prev_q;
    end
  end

  assign cmd_pulse = edge_q;

endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer #(
  parameter int unsigned LOW_MIN   = 80,
  parameter int unsigned HIGH_MIN  = 80,
  parameter int unsigned BUSY_LEN  = 1024,
  parameter int unsigned DLY_SHORT = 4096,
  parameter int unsigned DLY_LONG  = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_pin,
  input  logic cal_reg_bit,
  input  logic ext_mode,
  input  logic pd,
  input  logic dly_sel,
  input  logic phase_adj_en,
  input  logic rtd,
  output logic cal_busy,
  output logic cal_done
);

  import cal_seq_pkg::*;

  localparam int unsigned DLY_MAX = (DLY_LONG > DLY_SHORT) ? DLY_LONG : DLY_SHORT;
  localparam int unsigned CNT_MAX = (DLY_MAX > BUSY_LEN) ? DLY_MAX : BUSY_LEN;
  localparam int CW = $clog2(CNT_MAX);
  localparam logic [CW-1:0] SHORT_LAST = CW'(DLY_SHORT - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(DLY_LONG - 1);
  localparam logic [CW-1:0] BUSY_LAST  = CW'(BUSY_LEN - 1);

  logic rst_n_sync;
  logic pin_cmd;
  logic reg_cmd;
  logic cmd_sel;
  logic cmd_ok;

  cal_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  cal_pin_qualifier #(
    .LOW_MIN  (LOW_MIN),
    .HIGH_MIN (HIGH_MIN)
  ) u_pin_qual (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .cal_pin   (cal_pin),
    .cmd_pulse (pin_cmd)
  );

  cal_reg_edge u_reg_edge (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .cal_reg_bit (cal_reg_bit),
    .cmd_pulse   (reg_cmd)
  );

  // Request gating: source by mode, blocked by power-down and by the RTD rule.
  assign cmd_sel = ext_mode ? reg_cmd : pin_cmd;
  assign cmd_ok  = cmd_sel & ~pd & (~phase_adj_en | rtd);

  cal_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          done_q, done_d;
  logic [CW-1:0] dly_last;

  assign dly_last = dly_sel ? LONG_LAST : SHORT_LAST;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_INIT: begin
        cnt_en  = 1'b1;
        cnt_d   = '0;
        state_d = (cal_pin && !ext_mode) ? ST_IDLE : ST_WAIT;
      end
      ST_WAIT: begin
        if (!pd) begin
          cnt_en = 1'b1;
          if (cnt_q >= dly_last) begin
            state_d = ST_BUSY;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_IDLE: begin
        if (cmd_ok) begin
          state_d = ST_BUSY;
          cnt_en  = 1'b1;
          cnt_d   = '0;
        end
      end
      ST_BUSY: begin
        cnt_en = 1'b1;
        if (pd) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (cnt_q == BUSY_LAST) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_INIT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      state_q <= ST_INIT;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cal_busy = (state_q == ST_BUSY);
  assign cal_done = done_q;

endmodule

// File: rtl/cal_sequencer_checker.sv
module cal_sequencer_checker #(
  parameter int unsigned BUSY_LEN = 1024
) (
  input logic clk,
  input logic rst_n,
  input logic pd,
  input logic cal_busy,
  input logic cal_done
);

  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else begin
      run_q <= cal_busy ? run_q + 1 : 32'd0;
    end
  end

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done); // R4

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (!cal_busy && $past(cal_busy))); // R4

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (run_q == BUSY_LEN)); // R4

  AST_PD_BLOCKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> !cal_busy); // R10

  AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_busy) |-> (cal_done || $past(pd))); // R11

endmodule

bind cal_sequencer cal_sequencer_checker #(
  .BUSY_LEN (BUSY_LEN)
) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .pd       (pd),
  .cal_busy (cal_busy),
  .cal_done (cal_done)
);

// File: tb/cal_sequencer_test.sv
`timescale 1ns/100ps
module cal_sequencer_test;

  localparam int L  = 4;
  localparam int H  = 3;
  localparam int BL = 12;
  localparam int DS = 20;
  localparam int DL = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_pin = 1'b0;
  logic cal_reg_bit = 1'b0;
  logic ext_mode = 1'b0;
  logic pd = 1'b0;
  logic dly_sel = 1'b0;
  logic phase_adj_en = 1'b0;
  logic rtd = 1'b0;
  logic cal_busy;
  logic cal_done;

  always #2 clk = ~clk;

  cal_sequencer #(
    .LOW_MIN (L), .HIGH_MIN (H), .BUSY_LEN (BL), .DLY_SHORT (DS), .DLY_LONG (DL)
  ) uut (
    .clk (clk), .rst_n (rst_n), .cal_pin (cal_pin), .cal_reg_bit (cal_reg_bit),
    .ext_mode (ext_mode), .pd (pd), .dly_sel (dly_sel), .phase_adj_en (phase_adj_en),
    .rtd (rtd), .cal_busy (cal_busy), .cal_done (cal_done)
  );

  int cyc;
  int starts, dones, rise_cyc, run, done_run, wide_done;
  logic busy_prev, done_prev;
  int vectors = 0;
  int errors = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (cal_busy && !busy_prev) begin
        starts++;
        rise_cyc = cyc;
      end
      if (cal_busy) run = busy_prev ? run + 1 : 1;
      if (cal_done) begin
        dones++;
        done_run = run;
        if (done_prev) wide_done++;
      end
      busy_prev = cal_busy;
      done_prev = cal_done;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #0.5;
  endtask

  task automatic do_reset(input bit sel, input bit pin, input bit ext);
    step(1);
    rst_n = 1'b0;
    dly_sel = sel; cal_pin = pin; ext_mode = ext; pd = 1'b0;
    cal_reg_bit = 1'b0; phase_adj_en = 1'b0; rtd = 1'b0;
    starts = 0; dones = 0; rise_cyc = -1; run = 0; done_run = 0; wide_done = 0;
    busy_prev = 1'b0; done_prev = 1'b0;
    step(3);
    chk(cal_busy == 1'b0 && cal_done == 1'b0, "R1 outputs in reset", {cal_busy, cal_done}, 0);
    rst_n = 1'b1;
  endtask

  task automatic pin_pattern(input int lo, input int hi);
    cal_pin = 1'b0; step(lo);
    cal_pin = 1'b1; step(hi);
    cal_pin = 1'b0; step(1);
    cal_pin = 1'b1;
  endtask

  initial begin
    int tgt, s0, exp_n, d0;
    int pds[3] = '{0, 3, 7};

    // R2 / R3 / R4: power-up delay for both selections, with power-down holds
    for (int sel = 0; sel < 2; sel++) begin
      foreach (pds[k]) begin
        tgt = sel ? DL : DS;
        do_reset(sel[0], 1'b0, 1'b0);
        step(5);
        chk(starts == 0, "R1 idle after release", starts, 0);
        if (pds[k] > 0) begin
          pd = 1'b1; step(pds[k]); pd = 1'b0;
        end
        step(tgt + pds[k] + BL + 10);
        chk(rise_cyc == tgt + 3 + pds[k], "R2/R3 power-up start cycle", rise_cyc, tgt + 3 + pds[k]);
        chk(done_run == BL, "R4 busy length", done_run, BL);
        chk(dones == 1 && wide_done == 0, "R4 single done pulse", dones, 1);
      end
    end

    // R12: register request during power-up delay is ignored
    do_reset(1'b0, 1'b0, 1'b1);
    step(6); cal_reg_bit = 1'b1;
    step(DS + BL + 10);
    chk(rise_cyc == DS + 3, "R12 start not moved by early request", rise_cyc, DS + 3);
    chk(starts == 1, "R12 early request dropped", starts, 1);

    // R5: pin high at reset in normal mode suppresses power-up calibration
    do_reset(1'b1, 1'b1, 1'b0);
    step(DL + BL + 20);
    chk(starts == 0, "R5 power-up calibration suppressed", starts, 0);
    pin_pattern(L, H);
    step(BL + 8);
    chk(starts == 1, "R5 valid command after suppression", starts, 1);

    // R6: sweep of low/high run lengths around both limits
    do_reset(1'b0, 1'b1, 1'b1);
    step(DS + BL + 10);
    chk(starts == 1, "R5 pin high in extended mode keeps power-up calibration", starts, 1);
    ext_mode = 1'b0; step(2);
    for (int lo = 1; lo <= L + 1; lo++) begin
      for (int hi = 1; hi <= H + 1; hi++) begin
        s0 = starts;
        pin_pattern(lo, hi);
        step(BL + 10);
        exp_n = (lo >= L && hi >= H) ? 1 : 0;
        chk(starts - s0 == exp_n, $sformatf("R6 pin low %0d high %0d", lo, hi), starts - s0, exp_n);
      end
    end

    // R9 / R10: pin command gating by phase adjust, RTD and power-down
    for (int pa = 0; pa < 2; pa++) begin
      for (int rt = 0; rt < 2; rt++) begin
        phase_adj_en = pa[0]; rtd = rt[0];
        s0 = starts;
        pin_pattern(L, H + 2);
        step(BL + 10);
        exp_n = (pa == 0 || rt == 1) ? 1 : 0;
        chk(starts - s0 == exp_n, $sformatf("R9 pin pa %0d rtd %0d", pa, rt), starts - s0, exp_n);
      end
    end
    phase_adj_en = 1'b0; rtd = 1'b0;
    s0 = starts;
    pd = 1'b1;
    pin_pattern(L, H + 2);
    step(3);
    pd = 1'b0;
    step(BL + 10);
    chk(starts == s0, "R10 request during power-down discarded", starts - s0, 0);

    // R8: register bit ignored in normal mode
    s0 = starts;
    cal_reg_bit = 1'b0; step(3); cal_reg_bit = 1'b1; step(BL + 10);
    chk(starts == s0, "R8 register bit ignored in normal mode", starts - s0, 0);

    // R7 / R8 / R9 / R11 / R12: extended mode
    ext_mode = 1'b1; step(3);
    s0 = starts;
    pin_pattern(L, H + 2);
    step(BL + 10);
    chk(starts == s0, "R8 pin ignored in extended mode", starts - s0, 0);
    chk(starts == s0, "R7 bit already high gives no request", starts - s0, 0);
    cal_reg_bit = 1'b0; step(3); cal_reg_bit = 1'b1;
    step(4);
    chk(cal_busy == 1'b1, "R7 rising bit starts calibration", cal_busy, 1);
    cal_reg_bit = 1'b0; step(1); cal_reg_bit = 1'b1;
    step(BL + 10);
    chk(starts - s0 == 1, "R12 request while busy ignored", starts - s0, 1);
    step(3 * BL);
    chk(starts - s0 == 1, "R7 held bit gives no further request", starts - s0, 1);
    for (int pa = 0; pa < 2; pa++) begin
      for (int rt = 0; rt < 2; rt++) begin
        phase_adj_en = pa[0]; rtd = rt[0];
        s0 = starts;
        cal_reg_bit = 1'b0; step(3); cal_reg_bit = 1'b1;
        step(BL + 10);
        exp_n = (pa == 0 || rt == 1) ? 1 : 0;
        chk(starts - s0 == exp_n, $sformatf("R9 register pa %0d rtd %0d", pa, rt), starts - s0, exp_n);
      end
    end
    phase_adj_en = 1'b0; rtd = 1'b0;

    // R11: power-down aborts a running calibration
    s0 = starts; d0 = dones;
    cal_reg_bit = 1'b0; step(3); cal_reg_bit = 1'b1;
    step(6);
    chk(cal_busy == 1'b1, "R11 calibration running before abort", cal_busy, 1);
    pd = 1'b1; step(1);
    chk(cal_busy == 1'b0, "R11 busy drops after power-down", cal_busy, 0);
    step(BL + 5);
    pd = 1'b0;
    step(BL + 5);
    chk(dones == d0, "R11 no done after abort", dones - d0, 0);
    chk(starts - s0 == 1, "R11 no automatic restart", starts - s0, 1);
    cal_reg_bit = 1'b0; step(3); cal_reg_bit = 1'b1;
    step(BL + 10);
    chk(starts - s0 == 2 && dones - d0 == 1, "R11 new request completes", dones - d0, 1);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule